// File: doc/BRIEF.md
# Hot-Pixel Persistence Prefilter

This block sits at the front of a hot-region detector and works on a raster stream of grayscale pixels. It first turns each pixel into a single hot or cold bit. A pixel is hot when it reaches a global base level. If it lies inside a programmable rectangle, it must also reach a second, stricter level. The levels are compared directly in pixel units.

The block keeps, for every pixel position, the hot bits of the three frames before the current one. It adds these to the current bit, which gives a four-frame count. That count is equal to four times the mean of the thresholded frames. The output is white only when the count reaches a programmable minimum. With the recommended minimum of four, a spot that is hot for a single frame never gets through. A frame that arrived before reset, or that has not arrived yet, counts as cold.

The stream carries a frame-start and a line-start marker on the first pixel of each frame and of each line. The output is a binary stream in the same raster order, one cycle behind the input.

Top module: `hotmap_prefilter`

## Requirements
- R1: A pixel whose value is below `lvl_base` yields a cold bit for the current frame, wherever it lies.
- R2: A pixel inside the rectangle (`win_x0` ≤ column ≤ `win_x1` and `win_y0` ≤ row ≤ `win_y1`, bounds inclusive) whose value is below `lvl_win` yields a cold bit. A pixel inside the rectangle is hot only if it reaches both levels.
- R3: Outside the rectangle, `lvl_win` has no effect. There a pixel is hot exactly when its value is ≥ `lvl_base`.
- R4: `out_bit` is 1 exactly when the count of hot bits at the same position, over the current frame and the three frames before it, is ≥ `min_hits`.
- R5: A frame that did not occur since reset counts as cold. After reset, frame k (where 0 is the first frame) has at most k+1 hot frames in its count. With `min_hits` ≥ 2, every pixel of the first frame is black.
- R6: `out_valid` is `pix_valid` delayed by one clock. When `out_valid` is 0, `out_bit` is 0.
- R7: `pix_sof` places the pixel at column 0, row 0. `pix_sol` places it at column 0 of the next row. Any other valid pixel moves one column right. Cycles without `pix_valid` do not move the position.
- R8: While reset is asserted and right after it, `out_valid` and `out_bit` are 0 and no earlier frame is counted.
- R9: With `min_hits` = 4, a pixel that is hot in only one frame, or in any run of fewer than four consecutive frames, gives a black output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_valid | input | 1 | Input pixel present this cycle |
| pix_data | input | PIX_W | Grayscale pixel value |
| pix_sof | input | 1 | First pixel of a frame |
| pix_sol | input | 1 | First pixel of a line (not the first line) |
| lvl_base | input | PIX_W | Global hot level |
| lvl_win | input | PIX_W | Stricter level inside the rectangle |
| win_x0 | input | X_W | Rectangle first column |
| win_x1 | input | X_W | Rectangle last column |
| win_y0 | input | Y_W | Rectangle first row |
| win_y1 | input | Y_W | Rectangle last row |
| min_hits | input | 3 | Minimum hot count over four frames |
| out_valid | output | 1 | Output bit present |
| out_bit | output | 1 | 1 = persistent hot pixel |

## Verification
The embedded properties check the per-cycle rules on every cycle. These are the one-cycle delay from `pix_valid` to `out_valid`, a black output while idle, a black result for any pixel below the base level or below the rectangle level inside the rectangle, and a black first frame. The count across frames can only be shown by the bench's frame sequences. These cover the mix of fresh and stored history, the saturation of the fill level, the rejection of short-lived hot spots and the inclusive rectangle edges. The bench compares each pixel against its own model of the four-frame count.

// File: rtl/hpf_pkg.sv
package hpf_pkg;
  localparam int HIST_N = 3;                 // stored earlier frames
  typedef logic [HIST_N-1:0] hist_t;         // bit 0 = most recent frame
  typedef logic [1:0]        fill_t;         // earlier frames available, 0..3
  typedef logic [2:0]        hits_t;         // hot count 0..4
endpackage

// File: rtl/hpf_raster_pos.sv
module hpf_raster_pos #(
  parameter int X_W = 4,
  parameter int Y_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pix_valid,
  input  logic             pix_sof,
  input  logic             pix_sol,
  output logic [X_W-1:0]   cur_x,
  output logic [Y_W-1:0]   cur_y,
  output hpf_pkg::fill_t   cur_fill
);
  import hpf_pkg::*;

  logic [X_W-1:0] lx_q, lx_d;
  logic [Y_W-1:0] ly_q, ly_d;
  fill_t          fill_q, fill_d;
  logic           seen_q, seen_d;

  // position and fill level of the pixel on the inputs now
  always_comb begin
    cur_x = (pix_sof || pix_sol) ? '0 : lx_q + X_W'(1);
    if (pix_sof)      cur_y = '0;
    else if (pix_sol) cur_y = ly_q + Y_W'(1);
    else              cur_y = ly_q;
    if (pix_sof)
      cur_fill = !seen_q ? 2'd0 : ((fill_q == 2'd3) ? 2'd3 : fill_q + 2'd1);
    else
      cur_fill = fill_q;
  end

  always_comb begin
    lx_d   = lx_q;
    ly_d   = ly_q;
    fill_d = fill_q;
    seen_d = seen_q;
    if (pix_valid) begin
      lx_d   = cur_x;
      ly_d   = cur_y;
      fill_d = cur_fill;
      seen_d = seen_q | pix_sof;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lx_q   <= '0;
      ly_q   <= '0;
      fill_q <= '0;
      seen_q <= 1'b0;
    end else begin
      lx_q   <= lx_d;
      ly_q   <= ly_d;
      fill_q <= fill_d;
      seen_q <= seen_d;
    end
  end

  // R7: idle cycles leave the stored position alone
  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid |=> (lx_q == $past(lx_q)) && (ly_q == $past(ly_q)));
endmodule

// File: rtl/hpf_zone_thresh.sv
module hpf_zone_thresh #(
  parameter int PIX_W = 8,
  parameter int X_W   = 4,
  parameter int Y_W   = 3
) (
  input  logic [PIX_W-1:0] pix,
  input  logic [X_W-1:0]   x,
  input  logic [Y_W-1:0]   y,
  input  logic [PIX_W-1:0] lvl_base,
  input  logic [PIX_W-1:0] lvl_win,
  input  logic [X_W-1:0]   win_x0,
  input  logic [X_W-1:0]   win_x1,
  input  logic [Y_W-1:0]   win_y0,
  input  logic [Y_W-1:0]   win_y1,
  output logic             in_win,
  output logic             hot
);
  always_comb begin
    in_win = (x >= win_x0) && (x <= win_x1) && (y >= win_y0) && (y <= win_y1);
    hot    = (pix >= lvl_base) && (!in_win || (pix >= lvl_win));
  end
endmodule

// File: rtl/hpf_history.sv
module hpf_history #(
  parameter int DEPTH  = 128,
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid,
  input  logic [ADDR_W-1:0] addr,
  input  logic              hot,
  input  hpf_pkg::fill_t    fill,
  input  hpf_pkg::hits_t    min_hits,
  output logic              out_valid,
  output logic              out_bit
);
  import hpf_pkg::*;

  hist_t mem [DEPTH];
  hist_t rd;
  hits_t hits;
  logic  pass;
  logic  ov_q, ov_d, ob_q, ob_d;

  assign rd = mem[addr];

  // count only the earlier frames that exist since reset
  always_comb begin
    hits = {2'b00, hot};
    for (int k = 0; k < HIST_N; k++) begin
      if (2'(k) < fill) hits = hits + {2'b00, rd[k]};
    end
    pass = (hits >= min_hits);
  end

  always_ff @(posedge clk) begin
    if (valid) mem[addr] <= {rd[HIST_N-2:0], hot};
  end

  always_comb begin
    ov_d = valid;
    ob_d = valid & pass;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ov_q <= 1'b0;
      ob_q <= 1'b0;
    end else begin
      ov_q <= ov_d;
      ob_q <= ob_d;
    end
  end

  assign out_valid = ov_q;
  assign out_bit   = ob_q;

  p_first_frame_black_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && fill == 2'd0 && min_hits >= 3'd2) |=> !out_bit);
  p_valid_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> out_valid);
  p_idle_no_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |=> !out_valid);
  p_idle_black_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !out_bit);
endmodule

// File: rtl/hotmap_prefilter.sv
module hotmap_prefilter #(
  parameter int PIX_W = 8,
  parameter int IMG_W = 16,
  parameter int IMG_H = 8,
  localparam int X_W    = $clog2(IMG_W),
  localparam int Y_W    = $clog2(IMG_H),
  localparam int DEPTH  = IMG_W * IMG_H,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pix_valid,
  input  logic [PIX_W-1:0] pix_data,
  input  logic             pix_sof,
  input  logic             pix_sol,
  input  logic [PIX_W-1:0] lvl_base,
  input  logic [PIX_W-1:0] lvl_win,
  input  logic [X_W-1:0]   win_x0,
  input  logic [X_W-1:0]   win_x1,
  input  logic [Y_W-1:0]   win_y0,
  input  logic [Y_W-1:0]   win_y1,
  input  logic [2:0]       min_hits,
  output logic             out_valid,
  output logic             out_bit
);
  import hpf_pkg::*;

  logic [X_W-1:0]    cx;
  logic [Y_W-1:0]    cy;
  fill_t             cfill;
  logic              in_win, hot;
  logic [ADDR_W-1:0] addr;

  hpf_raster_pos #(.X_W(X_W), .Y_W(Y_W)) u_pos (
    .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_sof(pix_sof),
    .pix_sol(pix_sol), .cur_x(cx), .cur_y(cy), .cur_fill(cfill));

  hpf_zone_thresh #(.PIX_W(PIX_W), .X_W(X_W), .Y_W(Y_W)) u_thr (
    .pix(pix_data), .x(cx), .y(cy), .lvl_base(lvl_base), .lvl_win(lvl_win),
    .win_x0(win_x0), .win_x1(win_x1), .win_y0(win_y0), .win_y1(win_y1),
    .in_win(in_win), .hot(hot));

  assign addr = ADDR_W'(cy) * ADDR_W'(IMG_W) + ADDR_W'(cx);

  hpf_history #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_hist (
    .clk(clk), .rst_n(rst_n), .valid(pix_valid), .addr(addr), .hot(hot),
    .fill(cfill), .min_hits(min_hits), .out_valid(out_valid), .out_bit(out_bit));

  p_base_black_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && pix_data < lvl_base && min_hits >= 3'd4) |=> !out_bit);
  p_win_black_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && in_win && pix_data < lvl_win && min_hits >= 3'd4) |=> !out_bit);
endmodule

// File: tb/sim_hotmap_prefilter.sv
module sim_hotmap_prefilter;
  localparam int CLK_P = 10;
  localparam int W = 4;
  localparam int H = 2;
  localparam int NPX = W * H;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       pix_valid, pix_sof, pix_sol;
  logic [7:0] pix_data, lvl_base, lvl_win;
  logic [1:0] win_x0, win_x1;
  logic [0:0] win_y0, win_y1;
  logic [2:0] min_hits;
  logic       out_valid, out_bit;

  int errs = 0;
  int checks = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  hotmap_prefilter #(.PIX_W(8), .IMG_W(W), .IMG_H(H)) u0 (
    .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_data(pix_data),
    .pix_sof(pix_sof), .pix_sol(pix_sol), .lvl_base(lvl_base), .lvl_win(lvl_win),
    .win_x0(win_x0), .win_x1(win_x1), .win_y0(win_y0), .win_y1(win_y1),
    .min_hits(min_hits), .out_valid(out_valid), .out_bit(out_bit));

  // frames, pixel 0 in the low byte; row 1 holds pixels 4..7
  localparam logic [63:0] TBL [6] = '{
    {8'd30,  8'd200, 8'd199, 8'd120, 8'd250, 8'd100, 8'd99,  8'd150},
    {8'd100, 8'd200, 8'd210, 8'd255, 8'd250, 8'd100, 8'd200, 8'd150},
    {8'd100, 8'd150, 8'd210, 8'd255, 8'd250, 8'd100, 8'd200, 8'd150},
    {8'd99,  8'd250, 8'd210, 8'd255, 8'd250, 8'd100, 8'd200, 8'd150},
    {8'd101, 8'd250, 8'd210, 8'd255, 8'd250, 8'd100, 8'd30,  8'd150},
    {8'd255, 8'd255, 8'd255, 8'd255, 8'd250, 8'd100, 8'd200, 8'd0}
  };

  // bench model of the persistence rule
  logic [2:0] mh [NPX];
  int mfill;

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: got %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; pix_valid = 0; pix_sof = 0; pix_sol = 0; pix_data = 0;
    repeat (3) @(negedge clk);
    chk(out_valid, 1'b0, "R8 out_valid in reset");
    chk(out_bit, 1'b0, "R8 out_bit in reset");
    rst_n = 1'b1;
    for (int p = 0; p < NPX; p++) mh[p] = 3'b000;
    mfill = -1;
    @(negedge clk);
    chk(out_valid, 1'b0, "R8 out_valid after reset");
  endtask

  function automatic logic model_px(input int p, input logic [7:0] v);
    logic hb, inw;
    int hits, x, y;
    x = p % W; y = p / W;
    inw = (x >= win_x0) && (x <= win_x1) && (y >= win_y0) && (y <= win_y1);
    hb = (v >= lvl_base) && (!inw || v >= lvl_win);
    hits = hb;
    for (int k = 0; k < 3; k++) if (k < mfill) hits += mh[p][k];
    mh[p] = {mh[p][1:0], hb};
    return (hits >= min_hits);
  endfunction

  task automatic send_frame(input logic [63:0] f, input string tag);
    logic e;
    mfill = (mfill < 3) ? mfill + 1 : 3;
    for (int p = 0; p < NPX; p++) begin
      e = model_px(p, f[p*8 +: 8]);
      pix_valid = 1; pix_data = f[p*8 +: 8];
      pix_sof = (p == 0); pix_sol = (p % W == 0) && (p != 0);
      @(negedge clk);
      pix_valid = 0; pix_sof = 0; pix_sol = 0;
      chk(out_valid, 1'b1, "R6 out_valid one cycle after pixel");
      chk(out_bit, e, tag);
      @(negedge clk);
      if (p == 2) begin
        chk(out_valid, 1'b0, "R6 out_valid low in gap");
        chk(out_bit, 1'b0, "R6 out_bit low in gap");
      end
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: got timeout expected finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    lvl_base = 8'd100; lvl_win = 8'd200;
    win_x0 = 2'd1; win_x1 = 2'd2; win_y0 = 1'b1; win_y1 = 1'b1;
    min_hits = 3'd4;
    @(negedge clk);
    do_reset();
    // table walk: R1 base level, R2 inclusive rectangle, R3 outside, R4 count, R5 fill
    for (int i = 0; i < 6; i++) send_frame(TBL[i], "R1/R2/R3/R4/R5 table pixel");

    // R4 with a lower minimum: two of four frames suffice
    min_hits = 3'd2;
    send_frame(TBL[0], "R4 min_hits=2");
    send_frame(TBL[3], "R4 min_hits=2");

    // R5: first frame with min 1 shows the bare threshold; R3 raised inner level
    do_reset();
    min_hits = 3'd1; lvl_win = 8'd255;
    send_frame({8{8'd150}}, "R3/R5 first frame min_hits=1");
    lvl_win = 8'd200;

    // R9: single hot frame after cold ones is rejected, four in a row pass
    do_reset();
    min_hits = 3'd4;
    repeat (3) send_frame({8{8'd10}}, "R9 cold frame");
    send_frame({8{8'd250}}, "R9 single hot frame");
    send_frame({8{8'd10}}, "R9 cold after spike");
    repeat (4) send_frame({8{8'd250}}, "R9/R4 persistent hot");

    // R7: line start mid-row restarts column 0 of the next row
    do_reset();
    min_hits = 3'd1;
    pix_valid = 1; pix_sof = 1; pix_sol = 0; pix_data = 8'd150;
    @(negedge clk); pix_sof = 0; pix_sol = 1;   // goes to (0,1), outside rectangle
    @(negedge clk);
    chk(out_bit, 1'b1, "R7 sol moves to column 0 next row");
    pix_sol = 0;                                 // (1,1): inside, 150 < 200
    @(negedge clk);
    pix_valid = 0;
    chk(out_bit, 1'b0, "R7/R2 next column inside rectangle");
    @(negedge clk);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule